// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Access Port

This unit is the processor-facing register front end of a two-channel serial controller. Each channel appears on the bus as two locations only: a control location and a data location. Every configuration register sits behind the control location and is reached through a small pointer. A control write made while the pointer is zero loads a register number. The next control access to that channel, read or write, reaches the numbered register, and the pointer then falls back to zero. Each register access therefore costs two bus cycles. A plain control read with no register selected returns the channel's live status byte.

Each channel holds its own bank of 8-bit configuration registers. Register numbers 2 and 9 are a single pair shared by both channels. Register 9 also carries reset commands that clear one channel or everything. The block decodes the transmit and receive configuration fields into line-level outputs. Data-location accesses bypass the pointer entirely and become transmit-load and receive-take strobes for the serial datapath, which sits outside this block.

Top module: `sio_regport`

## Requirements
- R1: A control write to a channel whose pointer is zero loads bits 3:0 of the written byte into that channel's pointer. Bits 7:4 of that byte are ignored.
- R2: With a nonzero pointer, the next control access of that channel, read or write, reaches the selected register, and the pointer is zero from the following clock. Data-location accesses never change any pointer.
- R3: A control read at pointer zero returns the status byte and leaves the pointer at zero. The status byte has receive-ready at bit 0, transmit-empty at bit 2, carrier detect at bit 3, clear-to-send at bit 5 and break-seen at bit 7. All other bits read 0.
- R4: A control read of a nonzero register returns the last value stored there. Registers are private to each channel, except numbers 2 and 9, which both channels share.
- R5: Register 5 of a channel drives its line outputs: request-to-send from bit 1, transmit enable from bit 3, send-break from bit 4 and data-terminal-ready from bit 7.
- R6: Character-length codes map as follows: 00 is 5 bits, 01 is 7, 10 is 6 and 11 is 8. The transmit code is bits 6:5 of register 5 and the receive code is bits 7:6 of register 3. Bit 0 of register 3 is receive enable. Lengths are output as 4-bit counts.
- R7: Bits 7:6 of a register-9 write are a reset command. 01 clears channel B (index 1), 10 clears channel A (index 0), and 11 clears both channels and the shared registers. Register 9 keeps only bits 5:0, so the command bits read back as 0.
- R8: A single-channel reset leaves the other channel's registers and the shared registers unchanged.
- R9: A data-location write pulses tx_load for the addressed channel in the same cycle, with tx_byte equal to the written byte. A data-location read pulses rx_take for that channel and returns that channel's rx_byte lane.
- R10: A synchronous reset clears both pointers and all registers. After it, line outputs are 0 and both length outputs read 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ch | input | 1 | Channel select, 0 = A, 1 = B |
| bus_data | input | 1 | 1 = data location, 0 = control location |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the read cycle |
| st_rx_ready | input | 2 | Receive-ready per channel |
| st_tx_empty | input | 2 | Transmit-empty per channel |
| st_dcd | input | 2 | Carrier detect per channel |
| st_cts | input | 2 | Clear-to-send per channel |
| st_break | input | 2 | Break seen per channel |
| rx_byte | input | 16 | Received byte, channel A in 7:0 |
| rx_take | output | 2 | Receive-take strobe per channel |
| tx_load | output | 2 | Transmit-load strobe per channel |
| tx_byte | output | 8 | Byte for the transmit datapath |
| line_rts | output | 2 | Request-to-send per channel |
| line_dtr | output | 2 | Data-terminal-ready per channel |
| tx_enable | output | 2 | Transmit enable per channel |
| tx_break | output | 2 | Send-break per channel |
| tx_bits | output | 8 | Transmit length count, channel A in 3:0 |
| rx_enable | output | 2 | Receive enable per channel |
| rx_bits | output | 8 | Receive length count, channel A in 3:0 |

## Verification
The hardest state to reach from the ports is a reset command that lands on one channel while the other channel and the shared pair hold known, distinct contents. Reaching it needs a full two-cycle write on each side first, and then a register-9 write issued through the opposite channel's control location. The bench fills every bank from a vector table and reads it all back. It then fires each of the three reset commands in turn and reads survivors and victims through the pointer. A separate case pulls the reset input while a pointer is armed, to show that the next control read returns status rather than a register.

// File: rtl/sio_regport_pkg.sv
package sio_regport_pkg;
    // Bank geometry shared by all modules of the register port
    localparam int NCH  = 2;
    localparam int DW   = 8;
    localparam int NREG = 16;
    localparam int PW   = $clog2(NREG);
    localparam int CHW  = $clog2(NCH);
    localparam int LW   = 4;

    // Register numbers whose position the behaviour depends on
    localparam logic [PW-1:0] REG_RXCFG = PW'(3);
    localparam logic [PW-1:0] REG_TXCFG = PW'(5);
    localparam logic [PW-1:0] REG_SHA   = PW'(2);
    localparam logic [PW-1:0] REG_RST   = PW'(9);

    // Field positions in the transmit and receive configuration registers
    localparam int TX_RTS = 1;
    localparam int TX_EN  = 3;
    localparam int TX_BRK = 4;
    localparam int TX_LEN = 5;
    localparam int TX_DTR = 7;
    localparam int RX_EN  = 0;
    localparam int RX_LEN = 6;

    typedef enum logic [1:0] {
        RST_NONE = 2'b00,
        RST_CH_B = 2'b01,
        RST_CH_A = 2'b10,
        RST_ALL  = 2'b11
    } rst_cmd_e;

    // Convert a two-bit length code into a character bit count
    function automatic logic [LW-1:0] len_count(input logic [1:0] code);
        case (code)
            2'b00:   len_count = LW'(5);
            2'b01:   len_count = LW'(7);
            2'b10:   len_count = LW'(6);
            default: len_count = LW'(8);
        endcase
    endfunction
endpackage

// File: rtl/sio_ptr.sv
// Register pointer of one channel.
// A control write at pointer zero loads a register number. Any control
// access at a nonzero pointer returns it to zero on the next clock.
// Assumes acc is already qualified to this channel's control location.
module sio_ptr #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          wr,
    input  logic [PW-1:0] load_val,
    output logic [PW-1:0] ptr
);
    logic [PW-1:0] ptr_nxt;

    // Next pointer: load on a write at zero, fall back to zero after a register access
    always_comb begin
        ptr_nxt = ptr;
        if (acc) begin
            if (ptr != '0)
                ptr_nxt = '0;
            else if (wr)
                ptr_nxt = load_val;
        end
    end

    // Pointer state with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else
            ptr <= ptr_nxt;
    end

    a_r1_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr && ptr == '0) |=> ptr == $past(load_val));

    a_r2_ptr_return: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ptr != '0) |=> ptr == '0);

    a_r3_ptr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc) |=> $stable(ptr));
endmodule

// File: rtl/sio_chan_regs.sv
// Private register bank of one channel.
// A clear request wipes the whole bank and takes priority over a write.
// Assumes we is never raised with waddr zero, which is the pointer slot.
module sio_chan_regs
    import sio_regport_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int REG_CNT = 16,
    localparam int AW     = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] rx_cfg,
    output logic [DATA_W-1:0] tx_cfg
);
    logic [DATA_W-1:0] mem [REG_CNT];

    // Register storage: reset or clear wipes the bank, else a write stores one entry
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < REG_CNT; i++)
                mem[i] <= '0;
        end else if (we && waddr != '0) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port and the two configuration registers that feed decode
    always_comb begin
        rdata  = mem[raddr];
        rx_cfg = mem[REG_RXCFG];
        tx_cfg = mem[REG_TXCFG];
    end

    a_r5_txcfg_store: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr && waddr == REG_TXCFG) |=> tx_cfg == $past(wdata));

    a_r7_bank_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tx_cfg == '0 && rx_cfg == '0));
endmodule

// File: rtl/sio_shared_regs.sv
// The register pair common to both channels.
// Only a full reset command clears it. The caller strips any command
// bits from the write data before it arrives here.
module sio_shared_regs #(
    parameter int DATA_W = 8,
    parameter int AW     = 4,
    parameter logic [AW-1:0] NUM_A = AW'(2),
    parameter logic [AW-1:0] NUM_B = AW'(9)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] reg_a, reg_b;

    // Shared storage: clear has priority, otherwise store the addressed entry
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            reg_a <= '0;
            reg_b <= '0;
        end else if (we) begin
            if (waddr == NUM_A) reg_a <= wdata;
            if (waddr == NUM_B) reg_b <= wdata;
        end
    end

    // Read select between the two shared entries
    always_comb begin
        rdata = (raddr == NUM_A) ? reg_a : reg_b;
    end

    a_r7_shared_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (reg_a == '0 && reg_b == '0));
endmodule

// File: rtl/sio_regport.sv
// Register access port of a two-channel serial controller.
// Each channel has a control and a data location. Control accesses go
// through a per-channel pointer. Data accesses become datapath strobes.
// Assumes at most one access per cycle; a write wins over a read.
module sio_regport
    import sio_regport_pkg::*;
#(
    parameter int DATA_W  = DW,
    parameter int REG_CNT = NREG,
    parameter int CH_CNT  = NCH,
    localparam int AW     = $clog2(REG_CNT),
    localparam int CW     = $clog2(CH_CNT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_ch,
    input  logic                     bus_data,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [CH_CNT-1:0]        st_rx_ready,
    input  logic [CH_CNT-1:0]        st_tx_empty,
    input  logic [CH_CNT-1:0]        st_dcd,
    input  logic [CH_CNT-1:0]        st_cts,
    input  logic [CH_CNT-1:0]        st_break,
    input  logic [CH_CNT*DATA_W-1:0] rx_byte,
    output logic [CH_CNT-1:0]        rx_take,
    output logic [CH_CNT-1:0]        tx_load,
    output logic [DATA_W-1:0]        tx_byte,
    output logic [CH_CNT-1:0]        line_rts,
    output logic [CH_CNT-1:0]        line_dtr,
    output logic [CH_CNT-1:0]        tx_enable,
    output logic [CH_CNT-1:0]        tx_break,
    output logic [CH_CNT*LW-1:0]     tx_bits,
    output logic [CH_CNT-1:0]        rx_enable,
    output logic [CH_CNT*LW-1:0]     rx_bits
);
    localparam logic [DATA_W-1:0] CMD_MASK = {2'b11, {(DATA_W-2){1'b0}}};

    logic [AW-1:0]     ptr_q   [CH_CNT];
    logic [DATA_W-1:0] chan_rd [CH_CNT];
    logic [DATA_W-1:0] status  [CH_CNT];
    logic [AW-1:0]     sel_ptr;
    logic              ctl_wr, reg_wr, is_shared, sh_we;
    logic [DATA_W-1:0] sh_wdata, sh_rd;
    rst_cmd_e          cmd;
    logic [CH_CNT-1:0] clr_ch;
    logic              clr_sh;

    // Decode the control-side access and any reset command it carries
    always_comb begin
        sel_ptr   = ptr_q[bus_ch];
        ctl_wr    = !bus_data && bus_wr;
        reg_wr    = ctl_wr && sel_ptr != '0;
        is_shared = (sel_ptr == REG_SHA) || (sel_ptr == REG_RST);
        sh_we     = reg_wr && is_shared;
        sh_wdata  = (sel_ptr == REG_RST) ? (bus_wdata & ~CMD_MASK) : bus_wdata;
        cmd       = (reg_wr && sel_ptr == REG_RST) ? rst_cmd_e'(bus_wdata[DATA_W-1 -: 2])
                                                   : RST_NONE;
        clr_ch    = '0;
        clr_ch[0] = (cmd == RST_CH_A) || (cmd == RST_ALL);
        clr_ch[1] = (cmd == RST_CH_B) || (cmd == RST_ALL);
        clr_sh    = (cmd == RST_ALL);
    end

    sio_shared_regs #(
        .DATA_W(DATA_W), .AW(AW), .NUM_A(REG_SHA), .NUM_B(REG_RST)
    ) u_shared (
        .clk(clk), .rst_n(rst_n), .clr(clr_sh), .we(sh_we),
        .waddr(sel_ptr), .wdata(sh_wdata), .raddr(sel_ptr), .rdata(sh_rd)
    );

    for (genvar c = 0; c < CH_CNT; c++) begin : g_ch
        logic              hit, acc_c, we_c;
        logic [DATA_W-1:0] rx_cfg, tx_cfg;

        // Qualify bus activity to this channel
        always_comb begin
            hit   = (bus_ch == CW'(c));
            acc_c = hit && !bus_data && (bus_wr || bus_rd);
            we_c  = hit && reg_wr && !is_shared;
        end

        sio_ptr #(.PW(AW)) u_ptr (
            .clk(clk), .rst_n(rst_n), .acc(acc_c), .wr(bus_wr),
            .load_val(bus_wdata[AW-1:0]), .ptr(ptr_q[c])
        );

        sio_chan_regs #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_regs (
            .clk(clk), .rst_n(rst_n), .clr(clr_ch[c]), .we(we_c),
            .waddr(sel_ptr), .wdata(bus_wdata), .raddr(sel_ptr),
            .rdata(chan_rd[c]), .rx_cfg(rx_cfg), .tx_cfg(tx_cfg)
        );

        // Field decode into line outputs, length counts and the status byte
        always_comb begin
            line_rts[c]  = tx_cfg[TX_RTS];
            line_dtr[c]  = tx_cfg[TX_DTR];
            tx_enable[c] = tx_cfg[TX_EN];
            tx_break[c]  = tx_cfg[TX_BRK];
            rx_enable[c] = rx_cfg[RX_EN];
            tx_bits[c*LW +: LW] = len_count(tx_cfg[TX_LEN +: 2]);
            rx_bits[c*LW +: LW] = len_count(rx_cfg[RX_LEN +: 2]);
            status[c]    = '0;
            status[c][0] = st_rx_ready[c];
            status[c][2] = st_tx_empty[c];
            status[c][3] = st_dcd[c];
            status[c][5] = st_cts[c];
            status[c][7] = st_break[c];
            tx_load[c]   = hit && bus_data && bus_wr;
            rx_take[c]   = hit && bus_data && bus_rd && !bus_wr;
        end
    end

    // Read-data select: receive lane, status, shared pair or private bank
    always_comb begin
        tx_byte = bus_wdata;
        if (!bus_rd)
            bus_rdata = '0;
        else if (bus_data)
            bus_rdata = rx_byte[bus_ch*DATA_W +: DATA_W];
        else if (sel_ptr == '0)
            bus_rdata = status[bus_ch];
        else if (is_shared)
            bus_rdata = sh_rd;
        else
            bus_rdata = chan_rd[bus_ch];
    end

    a_r2_data_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data |=> (ptr_q[0] == $past(ptr_q[0]) && ptr_q[1] == $past(ptr_q[1])));

    a_r8_b_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ch[0] && !clr_ch[1]) |=> ($stable(tx_bits[2*LW-1:LW]) && $stable(rx_bits[2*LW-1:LW])
                                        && $stable(line_rts[1]) && $stable(rx_enable[1])));

    a_r8_a_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ch[1] && !clr_ch[0]) |=> ($stable(tx_bits[LW-1:0]) && $stable(rx_bits[LW-1:0])
                                        && $stable(line_rts[0]) && $stable(rx_enable[0])));

    a_r10_reset_lines: assert property (@(posedge clk)
        !rst_n |=> (line_rts == '0 && line_dtr == '0 && tx_enable == '0 && rx_enable == '0));
endmodule

// File: tb/sim_sio_regport.sv
module sim_sio_regport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ch = 1'b0, bus_data = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  st_rx_ready = '0, st_tx_empty = '0, st_dcd = '0, st_cts = '0, st_break = '0;
    logic [15:0] rx_byte = '0;
    logic [1:0]  rx_take, tx_load, line_rts, line_dtr, tx_enable, tx_break, rx_enable;
    logic [7:0]  tx_byte, tx_bits, rx_bits;
    int          nchk = 0, nfail = 0;

    always #5 clk = ~clk;

    sio_regport u0 (
        .clk(clk), .rst_n(rst_n), .bus_ch(bus_ch), .bus_data(bus_data),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .st_rx_ready(st_rx_ready), .st_tx_empty(st_tx_empty), .st_dcd(st_dcd),
        .st_cts(st_cts), .st_break(st_break), .rx_byte(rx_byte), .rx_take(rx_take),
        .tx_load(tx_load), .tx_byte(tx_byte), .line_rts(line_rts), .line_dtr(line_dtr),
        .tx_enable(tx_enable), .tx_break(tx_break), .tx_bits(tx_bits),
        .rx_enable(rx_enable), .rx_bits(rx_bits)
    );

    // {3'b0, channel, register, value written, value expected on readback}
    localparam logic [23:0] VEC [8] = '{
        24'h015A5A, 24'h11A5A5, 24'h0C3434, 24'h1D1212,
        24'h0FFFFF, 24'h027777, 24'h193F3F, 24'h144444
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic ch, input logic [7:0] v);
        @(negedge clk);
        bus_ch = ch; bus_data = 1'b0; bus_wr = 1'b1; bus_rd = 1'b0; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ctl_read(input logic ch, output logic [7:0] v);
        @(negedge clk);
        bus_ch = ch; bus_data = 1'b0; bus_wr = 1'b0; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_write(input logic ch, input logic [3:0] n, input logic [7:0] v);
        ctl_write(ch, {4'h0, n});
        ctl_write(ch, v);
    endtask

    task automatic reg_read(input logic ch, input logic [3:0] n, output logic [7:0] v);
        ctl_write(ch, {4'h0, n});
        ctl_read(ch, v);
    endtask

    task automatic data_write(input logic ch, input logic [7:0] v,
                              output logic [1:0] ld, output logic [7:0] b);
        @(negedge clk);
        bus_ch = ch; bus_data = 1'b1; bus_wr = 1'b1; bus_rd = 1'b0; bus_wdata = v;
        #1 ld = tx_load; b = tx_byte;
        @(negedge clk);
        bus_wr = 1'b0; bus_data = 1'b0;
    endtask

    task automatic data_read(input logic ch, output logic [7:0] v, output logic [1:0] tk);
        @(negedge clk);
        bus_ch = ch; bus_data = 1'b1; bus_wr = 1'b0; bus_rd = 1'b1;
        #1 v = bus_rdata; tk = rx_take;
        @(negedge clk);
        bus_rd = 1'b0; bus_data = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R10 watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [1:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: state after reset
        ctl_read(1'b0, v);            check("R10 status after reset", v, 8'h00);
        check("R10 tx_bits", tx_bits, 8'h55);
        check("R10 rx_bits", rx_bits, 8'h55);
        check("R10 line outputs", {line_rts, line_dtr, tx_enable, tx_break, rx_enable}, 10'h0);
        reg_read(1'b0, 4'd1, v);      check("R10 register cleared", v, 8'h00);

        // R4: table of writes, then full readback
        for (int i = 0; i < 8; i++)
            reg_write(VEC[i][20], VEC[i][19:16], VEC[i][15:8]);
        for (int i = 0; i < 8; i++) begin
            reg_read(VEC[i][20], VEC[i][19:16], v);
            check($sformatf("R4 vector %0d", i), v, {24'h0, VEC[i][7:0]});
        end
        reg_read(1'b1, 4'd2, v);      check("R4 shared reg via B", v, 8'h77);
        reg_read(1'b0, 4'd9, v);      check("R4 shared reg9 via A", v, 8'h3F);

        // R3: status layout and pointer stays at zero
        st_rx_ready = 2'b01; st_tx_empty = 2'b01; st_cts = 2'b01; st_break = 2'b01; st_dcd = 2'b10;
        ctl_read(1'b0, v);            check("R3 status A", v, 8'hA5);
        ctl_read(1'b0, v);            check("R3 status A repeat", v, 8'hA5);
        ctl_read(1'b1, v);            check("R3 status B", v, 8'h08);

        // R1: upper bits of pointer write ignored
        ctl_write(1'b0, 8'hF1);
        ctl_read(1'b0, v);            check("R1 pointer low bits", v, 8'h5A);

        // R2: pointer clears after access; data port does not move it
        ctl_read(1'b0, v);            check("R2 back to status", v, 8'hA5);
        ctl_write(1'b0, 8'h0C);
        data_write(1'b0, 8'h99, s, v);
        check("R9 tx_load", s, 2'b01);
        check("R9 tx_byte", v, 8'h99);
        ctl_read(1'b0, v);            check("R2 pointer survives data access", v, 8'h34);

        // R9: receive side
        rx_byte = 16'hBBAA;
        data_read(1'b1, v, s);
        check("R9 rx lane B", v, 8'hBB);
        check("R9 rx_take B", s, 2'b10);

        // R5 and R6: transmit configuration decode on channel A
        reg_write(1'b0, 4'd5, 8'hFA);
        check("R5 lines A", {line_dtr[0], tx_break[0], tx_enable[0], line_rts[0]}, 4'hF);
        check("R6 tx len 11", tx_bits[3:0], 4'd8);
        reg_write(1'b0, 4'd5, 8'h20); check("R6 tx len 01", tx_bits[3:0], 4'd7);
        check("R5 lines off", {line_dtr[0], tx_break[0], tx_enable[0], line_rts[0]}, 4'h0);
        reg_write(1'b0, 4'd5, 8'h40); check("R6 tx len 10", tx_bits[3:0], 4'd6);
        reg_write(1'b1, 4'd3, 8'hC1);
        check("R6 rx len 11 B", rx_bits[7:4], 4'd8);
        check("R6 rx enable B", rx_enable, 2'b10);
        reg_write(1'b1, 4'd3, 8'h40); check("R6 rx len 01 B", rx_bits[7:4], 4'd7);
        reg_write(1'b1, 4'd3, 8'h80); check("R6 rx len 10 B", rx_bits[7:4], 4'd6);
        check("R6 rx enable off", rx_enable, 2'b00);

        // R7 and R8: channel B reset issued through channel A
        reg_write(1'b0, 4'd9, 8'h40);
        check("R7 B len cleared", rx_bits[7:4], 4'd5);
        reg_read(1'b1, 4'd1, v);      check("R7 B reg1 cleared", v, 8'h00);
        reg_read(1'b1, 4'd4, v);      check("R7 B reg4 cleared", v, 8'h00);
        reg_read(1'b0, 4'd1, v);      check("R8 A reg1 kept", v, 8'h5A);
        reg_read(1'b0, 4'd2, v);      check("R8 shared kept", v, 8'h77);
        reg_read(1'b1, 4'd9, v);      check("R7 command bits read 0", v, 8'h00);
        // channel A reset issued through channel B
        reg_write(1'b1, 4'd9, 8'h85);
        reg_read(1'b0, 4'd1, v);      check("R7 A reg1 cleared", v, 8'h00);
        reg_read(1'b0, 4'd12, v);     check("R7 A reg12 cleared", v, 8'h00);
        reg_read(1'b0, 4'd9, v);      check("R7 reg9 low bits kept", v, 8'h05);
        reg_read(1'b1, 4'd2, v);      check("R8 shared kept after A reset", v, 8'h77);
        // full reset
        reg_write(1'b0, 4'd1, 8'h11);
        reg_write(1'b1, 4'd1, 8'h22);
        reg_write(1'b0, 4'd9, 8'hC0);
        reg_read(1'b0, 4'd1, v);      check("R7 full A", v, 8'h00);
        reg_read(1'b1, 4'd1, v);      check("R7 full B", v, 8'h00);
        reg_read(1'b1, 4'd2, v);      check("R7 full shared", v, 8'h00);

        // R10: reset input while a pointer is armed
        reg_write(1'b0, 4'd5, 8'hFA);
        ctl_write(1'b0, 8'h03);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R10 lines after mid reset", {line_rts[0], tx_enable[0]}, 2'b00);
        check("R10 tx len after mid reset", tx_bits[3:0], 4'd5);
        ctl_read(1'b0, v);            check("R10 pointer cleared", v, 8'hA5);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule